// File: doc/BRIEF.md
# Sequential Unsigned Multiply/Divide Unit

A shared arithmetic engine that runs one of four unsigned operations per request: a short multiply (16 by 8 bits), a long multiply (24 by 16 bits), a short divide (16 by 8 bits) and a long divide (24 by 16 bits). The caller raises a start strobe together with an operation code and two operands. The unit takes a copy of the operands, iterates two bits per cycle and finishes after a fixed number of cycles that depends only on the operation.

While it works, `busy_o` is high. Completion is marked by a one-cycle `done_o` pulse. The product or the quotient/remainder pair then stays on the outputs until the next accepted start. A zero divisor does not end the operation early. It raises `dz_o` and returns an all-ones quotient at the usual latency.

Top module: `muldiv_seq`

## Requirements
- R1: Operation code 0 (short multiply) gives `prod_o` = opa_i[15:0] × opb_i[7:0], a 24-bit value zero-extended to 40 bits. `done_o` rises 5 cycles after the accepting clock edge.
- R2: Operation code 1 (long multiply) gives `prod_o` = opa_i[23:0] × opb_i[15:0], a 40-bit value. `done_o` rises 12 cycles after the accepting edge.
- R3: Operation code 2 (short divide) gives a 16-bit quotient in `quot_o[15:0]` and an 8-bit remainder in `rem_o[7:0]`, with the upper bits of both zero. `done_o` rises 8 cycles after the accepting edge.
- R4: Operation code 3 (long divide) gives a 24-bit quotient in `quot_o` and a 16-bit remainder in `rem_o`. `done_o` rises 12 cycles after the accepting edge.
- R5: In the short modes (codes 0 and 2) only opa_i[15:0] and opb_i[7:0] are used. Higher operand bits have no effect on the result.
- R6: A divide with a zero divisor completes at its normal latency. It returns an all-ones quotient of the mode width (0xFFFF short, 0xFFFFFF long), a zero remainder, and `dz_o` high. `dz_o` is low while busy, after any multiply, and after a divide with a nonzero divisor.
- R7: `busy_o` is high from the accepting edge until the completion edge. `done_o` is high for exactly one cycle, in the cycle that `busy_o` falls.
- R8: A start strobe while `busy_o` is high is ignored. Neither the running operation nor its latency changes.
- R9: Operands and operation code are captured at the accepting edge. Changes to them afterwards do not alter the result.
- R10: Results and `dz_o` are held unchanged until the next accepted start. A start is accepted in the cycle `done_o` is high.
- R11: After reset, `busy_o`, `done_o`, `dz_o`, `prod_o`, `quot_o` and `rem_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when not busy |
| op_i | input | 2 | Operation code: 0 short mul, 1 long mul, 2 short div, 3 long div |
| opa_i | input | 24 | Multiplicand or dividend |
| opb_i | input | 16 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Last divide had a zero divisor |
| prod_o | output | 40 | Product of the last multiply |
| quot_o | output | 24 | Quotient of the last divide |
| rem_o | output | 16 | Remainder of the last divide |

## Verification
The start strobe is taken at a rising edge. `busy_o` is then visible from the following half cycle. `done_o`, the new result and `dz_o` appear after exactly 5, 12, 8 or 12 further edges, according to the operation code. The bench runs a behavioural model that counts down the same latency from its own record of the accepting edge. On every falling edge it compares busy, done, the zero-divisor flag and the held results, so a result that arrives one cycle early or late, or that drifts while idle, shows up as a miscompare in that cycle. Starts during busy, operand changes after acceptance, and a start placed on the done cycle are all applied against this model.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_L = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_L = 2'd3
  } md_op_e;

  function automatic logic op_is_div(md_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_long(md_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int LAT_MS = 5,
  parameter int LAT_ML = 12,
  parameter int LAT_DS = 8,
  parameter int LAT_DL = 12,
  parameter int IT_MS  = 4,
  parameter int IT_ML  = 8,
  parameter int IT_DS  = 8,
  parameter int IT_DL  = 12
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  md_op_e op_i,
  output logic   load_o,
  output logic   step_o,
  output logic   busy_o,
  output logic   done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q, stp_q, it_lim_q;
  logic [CNT_W-1:0] lat_sel, it_sel;

  always_comb begin
    unique case (op_i)
      OP_MUL_S: begin lat_sel = CNT_W'(LAT_MS - 1); it_sel = CNT_W'(IT_MS); end
      OP_MUL_L: begin lat_sel = CNT_W'(LAT_ML - 1); it_sel = CNT_W'(IT_ML); end
      OP_DIV_S: begin lat_sel = CNT_W'(LAT_DS - 1); it_sel = CNT_W'(IT_DS); end
      default:  begin lat_sel = CNT_W'(LAT_DL - 1); it_sel = CNT_W'(IT_DL); end
    endcase
  end

  assign load_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      stp_q    <= '0;
      it_lim_q <= '0;
    end else begin
      done_q <= busy_q && (cnt_q == '0);
      if (load_o) begin
        busy_q   <= 1'b1;
        cnt_q    <= lat_sel;
        stp_q    <= '0;
        it_lim_q <= it_sel;
      end else if (busy_q) begin
        stp_q <= stp_q + 1'b1;
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign step_o = busy_q && (stp_q < it_lim_q);
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q != '0) |=> busy_q && $stable(it_lim_q));
endmodule

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int A_W  = 24,
  parameter int B_W  = 16,
  parameter int STEP = 2,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] prod_o
);
  logic [P_W-1:0] mcand_q, acc_q, acc_nxt;
  logic [B_W-1:0] mplier_q;
  logic [P_W-1:0] pp [STEP];

  for (genvar j = 0; j < STEP; j++) begin : g_pp
    assign pp[j] = mplier_q[j] ? (mcand_q << j) : '0;
  end

  always_comb begin
    acc_nxt = acc_q;
    for (int j = 0; j < STEP; j++) acc_nxt = acc_nxt + pp[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= {{B_W{1'b0}}, a_i};
      mplier_q <= b_i;
      acc_q    <= '0;
    end else if (step_i) begin
      acc_q    <= acc_nxt;
      mcand_q  <= mcand_q << STEP;
      mplier_q <= mplier_q >> STEP;
    end
  end

  assign prod_o = acc_q;

  // R2
  acc_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> prod_o >= $past(prod_o));
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int N_W  = 24,
  parameter int D_W  = 16,
  parameter int STEP = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [N_W-1:0] dvd_i,
  input  logic [D_W-1:0] dsr_i,
  output logic [N_W-1:0] quo_o,
  output logic [D_W-1:0] rem_o
);
  logic [N_W-1:0] dvd_q, quo_q;
  logic [D_W-1:0] rem_q, dsr_q;
  logic [D_W-1:0] r [STEP+1];
  logic [STEP-1:0] qb;

  assign r[0] = rem_q;

  // restoring chain, one quotient bit per stage
  for (genvar j = 0; j < STEP; j++) begin : g_stage
    logic [D_W:0] trial, diff;
    logic         lt;
    assign trial = {r[j], dvd_q[N_W-1-j]};
    assign lt    = trial < {1'b0, dsr_q};
    assign diff  = trial - {1'b0, dsr_q};
    assign qb[STEP-1-j] = !lt;
    assign r[j+1] = lt ? trial[D_W-1:0] : diff[D_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
    end else if (load_i) begin
      dvd_q <= dvd_i;
      dsr_q <= dsr_i;
      quo_q <= '0;
      rem_q <= '0;
    end else if (step_i) begin
      dvd_q <= dvd_q << STEP;
      quo_q <= {quo_q[N_W-STEP-1:0], qb};
      rem_q <= r[STEP];
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R4
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsr_q != '0) && !load_i |=> (dsr_q == '0) || (rem_q < dsr_q));
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int A_W    = 24,
  parameter int B_W    = 16,
  parameter int AS_W   = 16,
  parameter int BS_W   = 8,
  parameter int STEP   = 2,
  parameter int LAT_MS = 5,
  parameter int LAT_ML = 12,
  parameter int LAT_DS = 8,
  parameter int LAT_DL = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           op_i,
  input  logic [A_W-1:0]       opa_i,
  input  logic [B_W-1:0]       opb_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 dz_o,
  output logic [A_W+B_W-1:0]   prod_o,
  output logic [A_W-1:0]       quot_o,
  output logic [B_W-1:0]       rem_o
);
  localparam int P_W    = A_W + B_W;
  localparam int IT_MS  = (BS_W + STEP - 1) / STEP;
  localparam int IT_ML  = (B_W + STEP - 1) / STEP;
  localparam int IT_DS  = (AS_W + STEP - 1) / STEP;
  localparam int IT_DL  = (A_W + STEP - 1) / STEP;
  localparam int LAT_MX = (LAT_ML > LAT_DL) ? LAT_ML : LAT_DL;
  localparam int CNT_W  = $clog2(LAT_MX + 1);

  md_op_e         op_in, op_q;
  logic           load, step, dz_q, longm;
  logic [A_W-1:0] a_sel, dvd_sel, div_quo;
  logic [B_W-1:0] b_sel, div_rem;

  assign op_in = md_op_e'(op_i);
  assign longm = op_is_long(op_in);

  // short modes use only the low operand bits
  assign a_sel   = longm ? opa_i : {{(A_W-AS_W){1'b0}}, opa_i[AS_W-1:0]};
  assign b_sel   = longm ? opb_i : {{(B_W-BS_W){1'b0}}, opb_i[BS_W-1:0]};
  assign dvd_sel = longm ? opa_i : {opa_i[AS_W-1:0], {(A_W-AS_W){1'b0}}};

  muldiv_ctrl #(
    .CNT_W(CNT_W), .LAT_MS(LAT_MS), .LAT_ML(LAT_ML), .LAT_DS(LAT_DS), .LAT_DL(LAT_DL),
    .IT_MS(IT_MS), .IT_ML(IT_ML), .IT_DS(IT_DS), .IT_DL(IT_DL)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .op_i   (op_in),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_MUL_S;
      dz_q <= 1'b0;
    end else if (load) begin
      op_q <= op_in;
      dz_q <= op_is_div(op_in) && (b_sel == '0);
    end
  end

  muldiv_mul #(.A_W(A_W), .B_W(B_W), .STEP(STEP)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load && !op_is_div(op_in)),
    .step_i(step && !op_is_div(op_q)),
    .a_i   (a_sel),
    .b_i   (b_sel),
    .prod_o(prod_o)
  );

  muldiv_div #(.N_W(A_W), .D_W(B_W), .STEP(STEP)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load && op_is_div(op_in)),
    .step_i(step && op_is_div(op_q)),
    .dvd_i (dvd_sel),
    .dsr_i (b_sel),
    .quo_o (div_quo),
    .rem_o (div_rem)
  );

  assign quot_o = div_quo;
  assign rem_o  = dz_q ? '0 : div_rem;
  assign dz_o   = dz_q && !busy_o;

  // R6
  dz_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dz_o |-> (op_q == OP_DIV_S) ? (quot_o == {{(A_W-AS_W){1'b0}}, {AS_W{1'b1}}})
                                          : (quot_o == {A_W{1'b1}}));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(prod_o) && $stable(quot_o) && $stable(rem_o) && $stable(dz_o));
  // R1
  short_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q == OP_MUL_S) |-> prod_o[P_W-1:AS_W+BS_W] == '0);
  // R3
  short_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q == OP_DIV_S) |-> (quot_o[A_W-1:AS_W] == '0) && (rem_o[B_W-1:BS_W] == '0));
endmodule

// File: tb/tb_muldiv_seq.sv
`timescale 1ns/1ps
module tb_muldiv_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [23:0] opa_i = '0;
  logic [15:0] opb_i = '0;
  logic        busy_o, done_o, dz_o;
  logic [39:0] prod_o;
  logic [23:0] quot_o;
  logic [15:0] rem_o;

  muldiv_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .dz_o(dz_o), .prod_o(prod_o), .quot_o(quot_o), .rem_o(rem_o)
  );

  always #2 clk = ~clk;

  int  vectors = 0, miscompares = 0, cyc = 0;
  bit  checking = 1'b0;

  // reference model state
  bit              m_busy, m_done, m_dz, have_mul, have_div, last_div, mul_short, div_short;
  int              m_cnt;
  bit [1:0]        m_op;
  longint unsigned e_prod;
  longint unsigned e_quo, e_rem;

  function automatic int lat_of(bit [1:0] op);
    case (op)
      2'd0: return 5;
      2'd1: return 12;
      2'd2: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_dz = 0; have_mul = 0; have_div = 0; last_div = 0;
      m_cnt = 0; m_op = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          last_div = m_op[1];
          if (m_op[1]) have_div = 1; else have_mul = 1;
        end
      end else if (start_i) begin
        longint unsigned a, b;
        m_op   = op_i;
        m_busy = 1;
        m_cnt  = lat_of(op_i);
        a = op_i[0] ? longint'(opa_i) : longint'(opa_i[15:0]);
        b = op_i[0] ? longint'(opb_i) : longint'(opb_i[7:0]);
        m_dz = op_i[1] && (b == 0);
        if (!op_i[1]) begin
          e_prod = a * b; mul_short = !op_i[0];
        end else begin
          div_short = !op_i[0];
          if (b == 0) begin
            e_quo = op_i[0] ? 64'hFFFFFF : 64'hFFFF; e_rem = 0;
          end else begin
            e_quo = a / b; e_rem = a % b;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      string lt;
      lt = (m_op == 2'd0) ? "R1" : (m_op == 2'd1) ? "R2" : (m_op == 2'd2) ? "R3" : "R4";
      chk(busy_o == m_busy, "R7 busy", busy_o, m_busy);
      chk(done_o == m_done, {lt, " done latency"}, done_o, m_done);
      chk(dz_o == (!m_busy && m_dz), "R6 dz flag", dz_o, !m_busy && m_dz);
      if (!m_busy && have_mul)
        chk(prod_o == e_prod, m_done ? (mul_short ? "R1 product" : "R2 product") : "R10 held product",
            prod_o, e_prod);
      if (!m_busy && have_div) begin
        chk(quot_o == e_quo, m_done ? (div_short ? "R3 quotient" : "R4 quotient") : "R10 held quotient",
            quot_o, e_quo);
        if (last_div)
          chk(rem_o == e_rem, m_done ? (div_short ? "R3 remainder" : "R4 remainder") : "R10 held remainder",
              rem_o, e_rem);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      miscompares++;
      $display("FAIL R7 watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // R9: operands scrambled right after acceptance
  task automatic issue(bit [1:0] op, logic [23:0] a, logic [15:0] b);
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0; op_i = 2'($urandom); opa_i = 24'($urandom); opb_i = 16'($urandom);
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(bit [1:0] op, logic [23:0] a, logic [15:0] b);
    issue(op, a, b);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk(busy_o == 0 && done_o == 0 && dz_o == 0, "R11 reset flags", {busy_o, done_o, dz_o}, 0);
    chk(prod_o == 0 && quot_o == 0 && rem_o == 0, "R11 reset results", prod_o | quot_o | rem_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    checking = 1'b1;

    // R1 R2 R3 R4 basics and extremes
    run(2'd0, 24'h001234, 16'h0056);
    run(2'd0, 24'h00FFFF, 16'h00FF);
    run(2'd1, 24'hFFFFFF, 16'hFFFF);
    run(2'd1, 24'h123456, 16'h0001);
    run(2'd2, 24'h00FFFF, 16'h0001);
    run(2'd2, 24'h000005, 16'h0009);
    run(2'd3, 24'hFFFFFF, 16'hFFFF);
    run(2'd3, 24'h89ABCD, 16'h0123);
    // R5: high bits must be ignored in short modes
    run(2'd0, 24'hAB1234, 16'hCD56);
    run(2'd2, 24'hFF8000, 16'h1203);
    // R6: zero divisor in both sizes, short one with nonzero upper bits
    run(2'd2, 24'h001234, 16'hAB00);
    run(2'd3, 24'h123456, 16'h0000);
    run(2'd0, 24'h000003, 16'h0003);
    // R8: starts while busy
    issue(2'd1, 24'h00F00D, 16'h0BAD);
    repeat (3) begin
      @(negedge clk);
      start_i = 1'b1; op_i = 2'd2; opa_i = 24'h111111; opb_i = 16'h0000;
    end
    @(negedge clk); start_i = 1'b0;
    wait_idle();
    // R10: start placed in the done cycle
    issue(2'd3, 24'h765432, 16'h0321);
    while (!done_o) @(negedge clk);
    start_i = 1'b1; op_i = 2'd0; opa_i = 24'h00BEEF; opb_i = 16'h00A5;
    @(negedge clk); start_i = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    // mixed random traffic
    for (int i = 0; i < 60; i++) begin
      logic [15:0] b;
      b = 16'($urandom);
      if (i % 9 == 0) b = 16'h0000;
      run(2'($urandom), 24'($urandom), b);
    end
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule